// File: doc/BRIEF.md
# Host Register Write Handshake

This block is the write side of a host slave port with an asynchronous strobe. The host places a read/write flag, a 3-bit register select and a data byte on the bus, then pulls an active-low strobe. The block brings the strobe into the core clock domain and detects its falling edge. It captures the select and data and issues a single-cycle register write toward the core. It then answers the host with an active-low acknowledge.

The acknowledge latency depends on the register that was written. Address bytes and the low data byte answer quickly. A high data byte aimed at the command queue takes a long fixed time. A high data byte aimed at memory waits a fixed time and then holds until an internal bus grant arrives. That wait may last several hundred clocks. Once the acknowledge is low, it stays low until the synchronised strobe is seen high again.

Top module: `host_wr_slave`

## Requirements
- R1: After reset, `host_ack_n` is high and `reg_wr_en` and `ibus_req` are low.
- R2: A strobe that falls while `host_rd_wrn` is 0 produces a write pulse on the third rising clock edge after the fall, counting the first edge that sees the strobe low as edge 1. `reg_wr_sel` and `reg_wr_data` then equal `host_sel` and `host_din`.
- R3: Each strobe falling edge yields exactly one write pulse, one cycle long, however long the strobe stays low.
- R4: For select codes 0, 1, 2, 3, 6 and 7, `host_ack_n` falls FAST_LAT (default 2) edges after the write-pulse edge, which is edge 5 from the strobe fall.
- R5: For select code 5 (command queue high byte), `host_ack_n` falls CMD_LAT (default 21) edges after the write-pulse edge, which is edge 24.
- R6: For select code 4 (memory high byte), `host_ack_n` falls MEM_LAT (default 6) edges after the write-pulse edge (edge 9) if `ibus_gnt` is high at that edge. Otherwise it falls at the first later edge that samples `ibus_gnt` high. `ibus_req` is high from the write-pulse edge until the edge where the acknowledge falls.
- R7: Once low, `host_ack_n` stays low while the strobe is held low. It returns high on the third rising edge after the strobe rises.
- R8: A strobe with `host_rd_wrn` at 1 produces no write pulse, no acknowledge and no bus request.
- R9: The level of `ibus_gnt` has no effect on the acknowledge timing of writes to codes other than 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_stb_n | input | 1 | Host strobe, active low, asynchronous to clk |
| host_rd_wrn | input | 1 | 1 = read (ignored), 0 = write |
| host_sel | input | SEL_W | Register select |
| host_din | input | DATA_W | Write data byte |
| host_ack_n | output | 1 | Acknowledge to host, active low |
| reg_wr_en | output | 1 | Single-cycle internal register write strobe |
| reg_wr_sel | output | SEL_W | Captured register select |
| reg_wr_data | output | DATA_W | Captured write data |
| ibus_req | output | 1 | High while a memory high-byte write waits for the internal bus |
| ibus_gnt | input | 1 | Internal bus grant that ends the variable wait |

## Verification
The bench drives every input on the falling clock edge. It counts rising edges from the strobe fall, so the write pulse is due on edge 3. The acknowledge is due on edge 5, 9 or 24, or on the edge after the grant is raised. Its release is due on the third edge after the strobe rises. Each of these is sampled on the falling edge that follows the edge where it is due. A behavioural model advances on every rising edge from its own history of strobe samples. It is compared with the acknowledge, write pulse, captured fields and bus request at every falling edge, so any result that arrives a cycle early or late is caught.

// File: rtl/hwr_pkg.sv
package hwr_pkg;

   // Latency class of a decoded register select
   typedef enum logic [1:0] {
      WK_FAST = 2'd0,
      WK_MEM  = 2'd1,
      WK_CMD  = 2'd2
   } wr_kind_t;

   // Handshake sequencer states
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_COUNT = 2'd1,
      ST_GRANT = 2'd2,
      ST_ACK   = 2'd3
   } hs_state_t;

endpackage

// File: rtl/hwr_sync.sv
module hwr_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o,
   output logic fall_o
);

   logic [STAGES-1:0] stage;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hwr_sync: STAGES must be at least 2");
      end
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage <= {STAGES{RST_VAL}};
            end else begin
               stage[0] <= async_i;
               stage[1] <= stage[0];
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage <= {STAGES{RST_VAL}};
            end else begin
               stage <= {stage[STAGES-2:0], async_i};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= stage[STAGES-1];
   end

   assign sync_o = stage[STAGES-1];
   assign fall_o = prev & ~stage[STAGES-1];

   // R3: a detected fall lasts one cycle only
   a_r3_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);

endmodule

// File: rtl/hwr_decode.sv
module hwr_decode
   import hwr_pkg::*;
#(
   parameter int SEL_W    = 3,
   parameter int MEM_SEL  = 4,
   parameter int CMD_SEL  = 5,
   parameter int FAST_LAT = 2,
   parameter int MEM_LAT  = 6,
   parameter int CMD_LAT  = 21,
   parameter int CNT_W    = 5
) (
   input  logic [SEL_W-1:0] sel,
   output wr_kind_t         kind,
   output logic [CNT_W-1:0] lat_m1
);

   localparam int NSEL = 2 ** SEL_W;

   wr_kind_t kind_tab [NSEL];

   generate
      for (genvar g = 0; g < NSEL; g++) begin : g_tab
         if (g == MEM_SEL) begin : g_mem
            assign kind_tab[g] = WK_MEM;
         end else if (g == CMD_SEL) begin : g_cmd
            assign kind_tab[g] = WK_CMD;
         end else begin : g_fast
            assign kind_tab[g] = WK_FAST;
         end
      end
   endgenerate

   assign kind = kind_tab[sel];

   always_comb begin
      unique case (kind)
         WK_MEM:  lat_m1 = CNT_W'(MEM_LAT - 1);
         WK_CMD:  lat_m1 = CNT_W'(CMD_LAT - 1);
         default: lat_m1 = CNT_W'(FAST_LAT - 1);
      endcase
   end

endmodule

// File: rtl/hwr_ctrl.sv
module hwr_ctrl
   import hwr_pkg::*;
#(
   parameter int SEL_W  = 3,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall,
   input  logic              strobe_hi,
   input  logic              rd_wrn,
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] din,
   input  wr_kind_t          kind,
   input  logic [CNT_W-1:0]  lat_m1,
   input  logic              grant,
   output logic              ack_n,
   output logic              wr_en,
   output logic [SEL_W-1:0]  wr_sel,
   output logic [DATA_W-1:0] wr_data,
   output logic              bus_req
);

   hs_state_t        state;
   wr_kind_t         kind_q;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         kind_q  <= WK_FAST;
         cnt     <= '0;
         ack_n   <= 1'b1;
         wr_en   <= 1'b0;
         wr_sel  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (fall && !rd_wrn) begin
                  wr_en   <= 1'b1;
                  wr_sel  <= sel;
                  wr_data <= din;
                  kind_q  <= kind;
                  cnt     <= lat_m1;
                  state   <= ST_COUNT;
               end
            end
            ST_COUNT: begin
               if (cnt == '0) begin
                  if (kind_q != WK_MEM || grant) begin
                     ack_n <= 1'b0;
                     state <= ST_ACK;
                  end else begin
                     state <= ST_GRANT;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_GRANT: begin
               if (grant) begin
                  ack_n <= 1'b0;
                  state <= ST_ACK;
               end
            end
            ST_ACK: begin
               if (strobe_hi) begin
                  ack_n <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign bus_req = (kind_q == WK_MEM) && (state == ST_COUNT || state == ST_GRANT);

   // R3: the write pulse is one cycle wide
   a_r3_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);
   // R4: acknowledge never coincides with the write pulse
   a_r4_ack_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ack_n);
   // R7: acknowledge holds while the synchronised strobe is low
   a_r7_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_n && !strobe_hi) |=> !ack_n);
   // R8: a read strobe starts no write
   a_r8_no_read_write: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && rd_wrn && state == ST_IDLE) |=> !wr_en);
   // R6: without a grant the memory wait does not acknowledge
   a_r6_wait_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_GRANT && !grant) |=> ack_n);
   // R6: the bus request ends only as the acknowledge falls
   a_r6_req_ends_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_req) |-> !ack_n);

endmodule

// File: rtl/host_wr_slave.sv
module host_wr_slave
   import hwr_pkg::*;
#(
   parameter int SEL_W       = 3,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int MEM_SEL     = 4,
   parameter int CMD_SEL     = 5,
   parameter int FAST_LAT    = 2,
   parameter int MEM_LAT     = 6,
   parameter int CMD_LAT     = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_stb_n,
   input  logic              host_rd_wrn,
   input  logic [SEL_W-1:0]  host_sel,
   input  logic [DATA_W-1:0] host_din,
   output logic              host_ack_n,
   output logic              reg_wr_en,
   output logic [SEL_W-1:0]  reg_wr_sel,
   output logic [DATA_W-1:0] reg_wr_data,
   output logic              ibus_req,
   input  logic              ibus_gnt
);

   localparam int MAX_AB  = (FAST_LAT > MEM_LAT) ? FAST_LAT : MEM_LAT;
   localparam int MAX_LAT = (MAX_AB > CMD_LAT) ? MAX_AB : CMD_LAT;
   localparam int CNT_W   = (MAX_LAT > 2) ? $clog2(MAX_LAT) : 1;

   generate
      if (FAST_LAT < 1 || MEM_LAT < 1 || CMD_LAT < 1) begin : g_bad_lat
         $error("host_wr_slave: every latency must be at least 1");
      end
      if (MEM_SEL == CMD_SEL) begin : g_bad_sel
         $error("host_wr_slave: MEM_SEL and CMD_SEL must differ");
      end
      if (MEM_SEL >= 2 ** SEL_W || CMD_SEL >= 2 ** SEL_W) begin : g_bad_range
         $error("host_wr_slave: select codes exceed SEL_W");
      end
   endgenerate

   logic             stb_hi;
   logic             stb_fall;
   wr_kind_t         dec_kind;
   logic [CNT_W-1:0] dec_lat_m1;

   hwr_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (host_stb_n),
      .sync_o  (stb_hi),
      .fall_o  (stb_fall)
   );

   hwr_decode #(
      .SEL_W    (SEL_W),
      .MEM_SEL  (MEM_SEL),
      .CMD_SEL  (CMD_SEL),
      .FAST_LAT (FAST_LAT),
      .MEM_LAT  (MEM_LAT),
      .CMD_LAT  (CMD_LAT),
      .CNT_W    (CNT_W)
   ) u_decode (
      .sel    (host_sel),
      .kind   (dec_kind),
      .lat_m1 (dec_lat_m1)
   );

   hwr_ctrl #(
      .SEL_W  (SEL_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .fall      (stb_fall),
      .strobe_hi (stb_hi),
      .rd_wrn    (host_rd_wrn),
      .sel       (host_sel),
      .din       (host_din),
      .kind      (dec_kind),
      .lat_m1    (dec_lat_m1),
      .grant     (ibus_gnt),
      .ack_n     (host_ack_n),
      .wr_en     (reg_wr_en),
      .wr_sel    (reg_wr_sel),
      .wr_data   (reg_wr_data),
      .bus_req   (ibus_req)
   );

   // R1: no write pulse while the acknowledge is already low
   a_r1_quiet_when_acked: assert property (@(posedge clk) disable iff (!rst_n)
      !host_ack_n |-> !reg_wr_en);

endmodule

// File: tb/host_wr_slave_bench.sv
module host_wr_slave_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stb_n = 1'b1;
   logic       rdwr = 1'b0;
   logic [2:0] sel = '0;
   logic [7:0] din = '0;
   logic       gnt = 1'b0;
   logic       ack_n;
   logic       wen;
   logic [2:0] wsel;
   logic [7:0] wdata;
   logic       req;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   host_wr_slave u_host_wr_slave (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_stb_n  (stb_n),
      .host_rd_wrn (rdwr),
      .host_sel    (sel),
      .host_din    (din),
      .host_ack_n  (ack_n),
      .reg_wr_en   (wen),
      .reg_wr_sel  (wsel),
      .reg_wr_data (wdata),
      .ibus_req    (req),
      .ibus_gnt    (gnt)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference, advanced on every rising edge
   int         m_st = 0;   // 0 idle, 1 counting, 2 grant wait, 3 acked
   int         m_cnt = 0;
   int         m_kind = 0; // 0 fast, 1 memory, 2 command
   bit         s1 = 1, s2 = 1, s3 = 1;
   bit         e_ack = 1, e_wen = 0, e_req = 0;
   logic [2:0] e_sel = '0;
   logic [7:0] e_data = '0;
   string      m_tag = "R1";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; e_ack = 1; e_wen = 0; e_req = 0;
         s1 = 1; s2 = 1; s3 = 1;
      end else begin
         e_wen = 0;
         if (m_st == 0) begin
            if (!s2 && s3 && !rdwr) begin
               e_wen = 1; e_sel = sel; e_data = din;
               m_kind = (sel == 3'd4) ? 1 : (sel == 3'd5) ? 2 : 0;
               m_cnt = (m_kind == 1) ? 5 : (m_kind == 2) ? 20 : 1;
               m_tag = (m_kind == 1) ? "R6" : (m_kind == 2) ? "R5" : "R4";
               e_req = (m_kind == 1);
               m_st = 1;
            end
         end else if (m_st == 1) begin
            if (m_cnt == 0) begin
               if (m_kind != 1 || gnt) begin
                  e_ack = 0; e_req = 0; m_st = 3; m_tag = "R7";
               end else m_st = 2;
            end else m_cnt--;
         end else if (m_st == 2) begin
            if (gnt) begin e_ack = 0; e_req = 0; m_st = 3; m_tag = "R7"; end
         end else begin
            if (s2) begin e_ack = 1; m_st = 0; end
         end
         s3 = s2; s2 = s1; s1 = stb_n;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check(ack_n == e_ack, {m_tag, " model ack_n"}, ack_n, e_ack);
         check(wen == e_wen, "R2 model reg_wr_en", wen, e_wen);
         check(req == e_req, "R6 model ibus_req", req, e_req);
         if (e_wen) begin
            check(wsel == e_sel, "R2 model reg_wr_sel", wsel, e_sel);
            check(wdata == e_data, "R2 model reg_wr_data", wdata, e_data);
         end
      end
   end

   // gnt_at: 0 = grant high from the start, >0 = raised after that edge, <0 = leave as is
   task automatic do_write(input logic [2:0] s, input logic [7:0] d, input int exp_ack,
                           input int gnt_at, input int hold, input string tag);
      int n = 0, pulses = 0, pn = -1;
      logic [2:0] pa = '0;
      logic [7:0] pd = '0;
      bit held_ok = 1;
      @(negedge clk);
      rdwr = 0; sel = s; din = d;
      if (gnt_at == 0) gnt = 1; else if (gnt_at > 0) gnt = 0;
      @(negedge clk);
      stb_n = 0;
      while (1) begin
         @(posedge clk); n++;
         @(negedge clk);
         if (gnt_at > 0 && n == gnt_at) gnt = 1;
         if (wen) begin pulses++; pn = n; pa = wsel; pd = wdata; end
         if (!ack_n || n > 2000) break;
      end
      check(n == exp_ack, {tag, " acknowledge edge"}, n, exp_ack);
      check(pn == 3, "R2 write pulse edge", pn, 3);
      check(pa == s && pd == d, "R2 captured fields", {pa, pd}, {s, d});
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         if (wen) pulses++;
         if (ack_n) held_ok = 0;
      end
      check(held_ok, "R7 ack held while strobe low", held_ok, 1);
      stb_n = 1;
      for (int r = 1; r <= 3; r++) begin
         @(negedge clk);
         if (wen) pulses++;
         check(ack_n == (r == 3), "R7 release edge", ack_n, (r == 3));
      end
      check(pulses == 1, "R3 one pulse per strobe", pulses, 1);
      if (gnt_at > 0) gnt = 0;
      repeat (3) @(negedge clk);
   endtask

   task automatic do_read(input logic [2:0] s);
      bit quiet = 1;
      @(negedge clk);
      rdwr = 1; sel = s; din = 8'hEE;
      @(negedge clk);
      stb_n = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (wen || !ack_n || req) quiet = 0;
      end
      stb_n = 1;
      repeat (5) begin
         @(negedge clk);
         if (wen || !ack_n || req) quiet = 0;
      end
      check(quiet, "R8 read strobe ignored", quiet, 1);
      rdwr = 0;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(ack_n == 1 && wen == 0 && req == 0, "R1 reset state", {ack_n, wen, req}, 3'b100);

      // R4: quick registers, varied data and hold times
      do_write(3'd0, 8'h12, 5, -1, 0, "R4");
      do_write(3'd1, 8'hA5, 5, -1, 3, "R4");
      do_write(3'd2, 8'h00, 5, -1, 1, "R4");
      do_write(3'd3, 8'hFF, 5, -1, 7, "R4");
      do_write(3'd6, 8'h5A, 5, -1, 0, "R4");
      do_write(3'd7, 8'h81, 5, -1, 2, "R4");
      // R5: command queue high byte, grant low then high (R9)
      do_write(3'd5, 8'h3C, 24, -1, 0, "R5");
      do_write(3'd5, 8'hC3, 24, 0, 4, "R9");
      // R9: grant high during quick writes
      do_write(3'd1, 8'h77, 5, 0, 1, "R9");
      // R6: memory high byte, grant early, at the count end, late, very late
      do_write(3'd4, 8'h11, 9, 0, 0, "R6");
      do_write(3'd4, 8'h22, 9, 4, 2, "R6");
      do_write(3'd4, 8'h33, 9, 8, 0, "R6");
      do_write(3'd4, 8'h44, 16, 15, 0, "R6");
      do_write(3'd4, 8'h55, 521, 520, 1, "R6");
      // R8: read strobes do nothing
      gnt = 0;
      do_read(3'd4);
      do_read(3'd0);
      // back-to-back write after a read
      do_write(3'd3, 8'h9D, 5, -1, 0, "R4");

      repeat (4) @(negedge clk);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule